// File: doc/BRIEF.md
# Mode-Width Accumulator ALU

This block is the arithmetic and logic stage for an accumulator that works at either 8 or 16 bits, selected cycle by cycle by a width-mode input. Each enabled clock it takes the accumulator value, one operand, an operation code and the incoming negative, overflow, zero and carry flags. One clock later it presents the result and the new flag set on registered outputs.

In 8-bit mode only the low byte is computed and written. The high byte of the accumulator passes through untouched. The carry position, the sign bit and the zero test all move to the byte boundary. The one exception is the half-swap operation: it always exchanges the two bytes of the full accumulator, and it takes its flags from the new low byte. Operand fetch and decimal arithmetic belong to other blocks.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 (add) returns A + operand + C_in at the current width. C_out is 1 when the unsigned sum exceeds FFh in 8-bit mode or FFFFh in 16-bit mode.
- R2: When `mode8` is 1, every operation except the half swap writes only bits 7:0. Bits 15:8 of `res` equal bits 15:8 of `acc_in`.
- R3: For add and subtract, V_out is 1 exactly when both addends have the same sign and the result sign differs from it. The addends are A and the operand for add, and A and the inverted operand for subtract. The sign bit is bit 7 in 8-bit mode and bit 15 in 16-bit mode.
- R4: Operation code 1 (subtract) returns A + ~operand + C_in at the current width. C_out = 1 means no borrow occurred.
- R5: Operation code 6 (logical shift right) moves A bit 0 into C_out and clears the top bit of the current width, so N_out is always 0.
- R6: Operation code 5 (shift left) and code 7 (rotate left) move the top bit of the current width into C_out. Code 5 fills bit 0 with 0 and code 7 fills it with C_in. Code 8 (rotate right) moves bit 0 into C_out and fills the top bit with C_in. Shifts and rotates leave V unchanged.
- R7: Codes 2, 3 and 4 (AND, OR, XOR with the operand) act on the current width and pass C_in and V_in through unchanged.
- R8: Codes 9 (increment) and 10 (decrement) wrap at the current width and pass C_in and V_in through unchanged.
- R9: Code 11 (half swap) exchanges bits 15:8 and 7:0 of A in either mode. N_out is bit 7 of the new value, Z_out is 1 when bits 7:0 of the new value are zero, and C and V pass through.
- R10: Except for the half swap and the unused codes, N_out is the top bit of the current-width result and Z_out is 1 when every bit of that result is zero.
- R11: Codes 12 to 15 are unused. They return `acc_in` and all four incoming flags unchanged.
- R12: Outputs update one clock after an edge with `en` high and hold while `en` is low. During reset and after it, until the first enabled edge, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Clock enable for the result and flag registers |
| op | input | 4 | Operation code |
| mode8 | input | 1 | 1 = 8-bit width, 0 = 16-bit width |
| acc_in | input | 16 | Accumulator value |
| opnd | input | 16 | Operand |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| z_in | input | 1 | Incoming zero flag |
| c_in | input | 1 | Incoming carry flag |
| res | output | 16 | Registered result |
| n_out | output | 1 | Registered negative flag |
| v_out | output | 1 | Registered overflow flag |
| z_out | output | 1 | Registered zero flag |
| c_out | output | 1 | Registered carry flag |

## Verification
The assertions take for granted that `op`, `mode8`, `acc_in` and the incoming flags are valid binary values on every edge with `en` high. The flag-preservation and high-byte checks compare an output against the input value sampled one cycle earlier. The stimulus therefore drives every input from the bench on the falling edge only, and holds it through the next rising edge. Unused operation codes and cycles with `en` low are mixed in on purpose, so the hold and pass-through properties see real traffic.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_ROL  = 4'd7,
    OP_ROR  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_SWAP = 4'd11,
    OP_RS12 = 4'd12,
    OP_RS13 = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int DATA_W = 16,
  localparam int HALF = DATA_W / 2
) (
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] y,
  output logic              cout,
  output logic              ovf
);
  logic [DATA_W:0] sum_full;
  logic [HALF:0]   sum_half;

  always_comb begin
    sum_full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    sum_half = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
    if (wide) begin
      y    = sum_full[DATA_W-1:0];
      cout = sum_full[DATA_W];
      ovf  = (a[DATA_W-1] == b[DATA_W-1]) && (sum_full[DATA_W-1] != a[DATA_W-1]);
    end else begin
      y    = {{HALF{1'b0}}, sum_half[HALF-1:0]};
      cout = sum_half[HALF];
      ovf  = (a[HALF-1] == b[HALF-1]) && (sum_half[HALF-1] != a[HALF-1]);
    end
  end
endmodule

// File: rtl/acc_logic.sv
module acc_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic_sel_e        sel,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int DATA_W = 16,
  localparam int HALF = DATA_W / 2
) (
  input  logic              wide,
  input  logic              left,
  input  logic              rot,
  input  logic              swap,
  input  logic              cin,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] y,
  output logic              cout
);
  logic fill;
  logic top_bit;

  always_comb begin
    fill    = rot & cin;
    top_bit = wide ? a[DATA_W-1] : a[HALF-1];
    y       = '0;
    cout    = 1'b0;
    if (swap) begin
      y = {a[HALF-1:0], a[DATA_W-1:HALF]};
    end else if (left) begin
      y    = {a[DATA_W-2:0], fill};
      cout = top_bit;
    end else begin
      cout = a[0];
      if (wide) y = {fill, a[DATA_W-1:1]};
      else      y[HALF-1:0] = {fill, a[HALF-1:1]};
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [OP_W-1:0]   op,
  input  logic              mode8,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd,
  input  logic              n_in,
  input  logic              v_in,
  input  logic              z_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              n_out,
  output logic              v_out,
  output logic              z_out,
  output logic              c_out
);
  logic rst_sync_n;
  acc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  alu_op_e op_e;
  logic    wide;
  assign op_e = alu_op_e'(op);
  assign wide = ~mode8;

  // adder operand selection
  logic [DATA_W-1:0] add_b, add_y;
  logic              add_ci, add_co, add_v;
  always_comb begin
    add_b  = opnd;
    add_ci = c_in;
    case (op_e)
      OP_SUB: add_b = ~opnd;
      OP_INC: begin add_b = {{(DATA_W-1){1'b0}}, 1'b1}; add_ci = 1'b0; end
      OP_DEC: begin add_b = '1; add_ci = 1'b0; end
      default: ;
    endcase
  end

  acc_adder #(.DATA_W(DATA_W)) u_add (
    .wide(wide), .a(acc_in), .b(add_b), .cin(add_ci),
    .y(add_y), .cout(add_co), .ovf(add_v)
  );

  logic_sel_e        lg_sel;
  logic [DATA_W-1:0] lg_y;
  always_comb begin
    case (op_e)
      OP_AND:  lg_sel = LG_AND;
      OP_OR:   lg_sel = LG_OR;
      default: lg_sel = LG_XOR;
    endcase
  end

  acc_logic #(.DATA_W(DATA_W)) u_log (
    .sel(lg_sel), .a(acc_in), .b(opnd), .y(lg_y)
  );

  logic              sh_left, sh_rot, sh_swap, sh_co;
  logic [DATA_W-1:0] sh_y;
  assign sh_left = (op_e == OP_SHL) || (op_e == OP_ROL);
  assign sh_rot  = (op_e == OP_ROL) || (op_e == OP_ROR);
  assign sh_swap = (op_e == OP_SWAP);

  acc_shifter #(.DATA_W(DATA_W)) u_sh (
    .wide(wide), .left(sh_left), .rot(sh_rot), .swap(sh_swap),
    .cin(c_in), .a(acc_in), .y(sh_y), .cout(sh_co)
  );

  // next-state: result merge and flag generation
  logic [DATA_W-1:0] core_y, res_d;
  flags_t            flg_d;
  logic              width_nz;
  always_comb begin
    core_y   = acc_in;
    flg_d    = '{n: n_in, v: v_in, z: z_in, c: c_in};
    width_nz = 1'b1;
    case (op_e)
      OP_ADD, OP_SUB: begin
        core_y  = add_y;
        flg_d.c = add_co;
        flg_d.v = add_v;
      end
      OP_INC, OP_DEC:        core_y = add_y;
      OP_AND, OP_OR, OP_XOR: core_y = lg_y;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        core_y  = sh_y;
        flg_d.c = sh_co;
      end
      OP_SWAP: begin
        core_y   = sh_y;
        width_nz = 1'b0;
      end
      default: width_nz = 1'b0;
    endcase

    if (mode8 && !sh_swap) res_d = {acc_in[DATA_W-1:HALF], core_y[HALF-1:0]};
    else                   res_d = core_y;

    if (width_nz) begin
      flg_d.n = mode8 ? core_y[HALF-1] : core_y[DATA_W-1];
      flg_d.z = mode8 ? (core_y[HALF-1:0] == '0) : (core_y == '0);
    end else if (sh_swap) begin
      flg_d.n = core_y[HALF-1];
      flg_d.z = (core_y[HALF-1:0] == '0);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res   <= '0;
      n_out <= 1'b0;
      v_out <= 1'b0;
      z_out <= 1'b0;
      c_out <= 1'b0;
    end else if (en) begin
      res   <= res_d;
      n_out <= flg_d.n;
      v_out <= flg_d.v;
      z_out <= flg_d.z;
      c_out <= flg_d.c;
    end
  end

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> $stable(res) && $stable({n_out, v_out, z_out, c_out}));

  // R2
  hi_byte_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && mode8 && op != OP_SWAP) |=> res[DATA_W-1:HALF] == $past(acc_in[DATA_W-1:HALF]));

  // R5
  shr_neg_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && op == OP_SHR) |=> !n_out);

  // R7
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (c_out == $past(c_in)) && (v_out == $past(v_in)));

  // R8
  incdec_cv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && (op == OP_INC || op == OP_DEC))
      |=> (c_out == $past(c_in)) && (v_out == $past(v_in)));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && op <= OP_DEC) |=>
      z_out == ($past(mode8) ? (res[HALF-1:0] == '0) : (res == '0)));

  // R9
  swap_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && op == OP_SWAP) |=> (n_out == res[HALF-1]) && (z_out == (res[HALF-1:0] == '0)));
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  op;
  logic        mode8;
  logic [15:0] acc_in, opnd;
  logic        n_in, v_in, z_in, c_in;
  logic [15:0] res;
  logic        n_out, v_out, z_out, c_out;

  always #2 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .mode8(mode8),
    .acc_in(acc_in), .opnd(opnd), .n_in(n_in), .v_in(v_in), .z_in(z_in), .c_in(c_in),
    .res(res), .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] exp_r = '0;
  logic [3:0]  exp_f = '0;   // {n,v,z,c}

  task automatic compare(input string tag);
    checks++;
    if (res !== exp_r || {n_out, v_out, z_out, c_out} !== exp_f) begin
      fails++;
      $display("FAIL %s: got res=%h nvzc=%b expected res=%h nvzc=%b",
               tag, res, {n_out, v_out, z_out, c_out}, exp_r, exp_f);
    end
  endtask

  task automatic model(input logic [3:0] o, input logic m, input logic [15:0] a, b,
                       input logic [3:0] fin);
    logic [16:0] mask, sb, al, bl, s, rl;
    logic n, v, z, c;
    mask = m ? 17'h000FF : 17'h0FFFF;
    sb   = m ? 17'h00080 : 17'h08000;
    al   = {1'b0, a} & mask;
    bl   = {1'b0, b} & mask;
    {n, v, z, c} = fin;
    rl = al;
    case (o)
      4'd0, 4'd1: begin
        if (o == 4'd1) bl = ~bl & mask;
        s  = al + bl + {16'd0, fin[0]};
        rl = s & mask;
        c  = (s > mask);
        v  = (((al ^ rl) & (bl ^ rl) & sb) != 0);
      end
      4'd2: rl = al & bl;
      4'd3: rl = al | bl;
      4'd4: rl = al ^ bl;
      4'd5, 4'd7: begin
        c  = ((al & sb) != 0);
        rl = ((al << 1) | ((o == 4'd7 && fin[0]) ? 17'd1 : 17'd0)) & mask;
      end
      4'd6, 4'd8: begin
        c  = al[0];
        rl = (al >> 1) | ((o == 4'd8 && fin[0]) ? sb : 17'd0);
      end
      4'd9:  rl = (al + 17'd1) & mask;
      4'd10: rl = (al + mask) & mask;
      default: ;
    endcase
    if (o == 4'd11) begin
      exp_r = {a[7:0], a[15:8]};
      exp_f = {exp_r[7], v, (exp_r[7:0] == 8'd0), c};
    end else if (o >= 4'd12) begin
      exp_r = a;
      exp_f = fin;
    end else begin
      exp_r = m ? {a[15:8], rl[7:0]} : rl[15:0];
      exp_f = {((rl & sb) != 0), v, (rl == 0), c};
    end
  endtask

  task automatic step(input string tag, input logic e, input logic [3:0] o, input logic m,
                      input logic [15:0] a, b, input logic [3:0] fin);
    @(negedge clk);
    en = e; op = o; mode8 = m; acc_in = a; opnd = b;
    {n_in, v_in, z_in, c_in} = fin;
    @(posedge clk);
    if (e) model(o, m, a, b, fin);
    #1 compare(tag);
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R4";
      4'd2, 4'd3, 4'd4: return "R7";
      4'd6: return "R5";
      4'd5, 4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R8";
      4'd11: return "R9";
      default: return "R11";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; en = 1'b0; op = '0; mode8 = 1'b0; acc_in = '0; opnd = '0;
    {n_in, v_in, z_in, c_in} = '0;
    repeat (3) @(posedge clk);
    #1 compare("R12 reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R12 after reset");

    // R1 add at 16 bits: signed overflow, then carry+overflow with zero
    step("R1 R3 7000+7000", 1, 4'd0, 0, 16'h7000, 16'h7000, 4'b0000);
    step("R1 R3 8000+8000", 1, 4'd0, 0, 16'h8000, 16'h8000, 4'b0000);
    // R2 8-bit add with carry in, high byte untouched
    step("R1 R2 8-bit carry", 1, 4'd0, 1, 16'h12FF, 16'h0001, 4'b0001);
    // R4 subtract
    step("R4 5-3", 1, 4'd1, 0, 16'h0005, 16'h0003, 4'b0001);
    step("R4 3-5 borrow", 1, 4'd1, 0, 16'h0003, 16'h0005, 4'b0001);
    step("R3 R4 8-bit 80-01", 1, 4'd1, 1, 16'hAA80, 16'h0001, 4'b0001);
    // R7 logic ops keep C and V
    step("R7 AND", 1, 4'd2, 1, 16'h5545, 16'h0040, 4'b0101);
    step("R7 XOR zero", 1, 4'd4, 0, 16'h00FF, 16'h00FF, 4'b1101);
    // R6 shifts and rotates
    step("R6 R2 SHL 8-bit", 1, 4'd5, 1, 16'hAB80, 16'h0000, 4'b0100);
    step("R6 ROL 16", 1, 4'd7, 0, 16'h8000, 16'h0000, 4'b0001);
    step("R5 SHR 16", 1, 4'd6, 0, 16'h0001, 16'h0000, 4'b1000);
    step("R6 ROR 8", 1, 4'd8, 1, 16'h1202, 16'h0000, 4'b0001);
    // R8 increment / decrement wrap
    step("R8 INC wrap", 1, 4'd9, 0, 16'hFFFF, 16'h0000, 4'b0101);
    step("R8 DEC 8-bit", 1, 4'd10, 1, 16'h3400, 16'h0000, 4'b0110);
    // R9 half swap
    step("R9 swap 16", 1, 4'd11, 0, 16'h0080, 16'h0000, 4'b0101);
    step("R9 swap mode8", 1, 4'd11, 1, 16'h80FF, 16'h0000, 4'b0010);
    // R11 unused code, R12 hold
    step("R11 unused", 1, 4'd13, 1, 16'hBEEF, 16'h1234, 4'b1010);
    step("R12 hold", 0, 4'd0, 0, 16'h1111, 16'h2222, 4'b1111);
    step("R10 zero 8-bit", 1, 4'd3, 1, 16'hFF00, 16'h0000, 4'b0000);

    for (int i = 0; i < 800; i++) begin
      logic [3:0] o;
      logic e;
      o = 4'($urandom_range(0, 15));
      e = ($urandom_range(0, 7) != 0);
      step(e ? tag_of(o) : "R12", e, o, 1'($urandom),
           16'($urandom), 16'($urandom), 4'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule